// File: doc/BRIEF.md
# Clock Throttling Duty-Cycle Generator

This block slows a processor down by gating its clock in a repeating pattern. Time is split into frames of 2^W slots, where W is the duty width parameter (3 by default, which gives eight slots). A programmed duty value N chooses how many slots at the start of each frame let the clock run. The active-low stop-clock output is driven low for the remaining slots of the frame, so the processor sees an average speed of N / 2^W of full rate.

Software programs the block through a small register-style write port. Each write carries a duty field and an enable bit. The duty field is accepted only while the block is disabled. To reprogram, software clears enable, writes the new duty, and then sets enable again. Slots advance only on a single-cycle tick input, so the frame length can be scaled from the block clock. A duty of zero is a reserved code and keeps the clock running. The write port is a plain control strobe with no ready signal and no back-pressure: the block accepts every write in the cycle in which it is presented.

Top module: `throttle_duty_gen`

## Requirements
- R1: After reset, enable is 0, the stored duty is 0 and stop_clk_n is 1.
- R2: While enable is 0, stop_clk_n stays 1 on every cycle, whatever the tick and duty inputs do.
- R3: While enable is 1 and the duty N is not 0, stop_clk_n is 1 in slots 0 to N-1 and 0 in slots N to 2^W-1. The slot index moves up by one on each clock edge where tick_i is 1, and wraps from 2^W-1 back to 0.
- R4: A stored duty of 0 is reserved. With that duty, stop_clk_n stays 1 even when enable is 1.
- R5: A write that changes enable from 0 to 1 sets the slot index to 0 on the same clock edge. A tick on that edge is ignored.
- R6: A write made while enable is 1 does not change the stored duty. The enable bit of that write still takes effect, so the same write can clear enable.
- R7: A duty written while enable is 0 is kept. It is used from the next rise of enable onward. A single write may carry both the new duty and enable = 1.
- R8: When ticks arrive on every cycle, each full frame contains exactly N slots with stop_clk_n = 1, for every N from 1 to 2^W-1. The delivered rate is never below N / 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the control word |
| wr_duty_i | input | DUTY_W | Duty field of the write |
| wr_enable_i | input | 1 | Enable bit of the write |
| tick_i | input | 1 | Single-cycle slot-advance qualifier |
| stop_clk_n_o | output | 1 | Stop-clock request, active low |

## Verification
The bench goes after four kinds of mistake. A design that reset the frame counter on the wrong edge, or let a tick through on the enable edge, would start the frame one slot late or early. A design that accepted a duty write while enabled would change the run/stop split in the middle of a throttle session. A design that did not treat zero as reserved would stop the clock for a whole frame, or for the entire time. For every duty from 1 to the maximum, the bench counts the running slots in a full frame, which catches off-by-one comparisons at the boundary between running and stopped slots. Random writes and tick patterns then compare every cycle against a reference model kept in the bench.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

  // Per-slot decision made by the pattern stage.
  typedef enum logic [1:0] {
    TH_IDLE     = 2'd0,  // throttling disabled, clock runs
    TH_RESERVED = 2'd1,  // duty code zero, clock runs
    TH_RUN      = 2'd2,  // enabled, slot inside the running part
    TH_STOP     = 2'd3   // enabled, slot inside the stopped part
  } th_phase_e;

  function automatic logic phase_stops(th_phase_e ph);
    return ph == TH_STOP;
  endfunction

endpackage

// File: rtl/throttle_ctrl_reg.sv
module throttle_ctrl_reg #(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              en_i,
  output logic              en_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              start_o
);

  logic              en_q;
  logic [DUTY_W-1:0] duty_q;
  logic              duty_open;

  // The duty field is writable only while throttling is off.
  assign duty_open = ~en_q;
  // Edge event: this write turns throttling on.
  assign start_o   = wr_i & en_i & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      duty_q <= '0;
    end else if (wr_i) begin
      en_q <= en_i;
      if (duty_open) duty_q <= duty_i;
    end
  end

  assign en_o   = en_q;
  assign duty_o = duty_q;

  // R6: the duty is frozen across any cycle pair where enable stays high
  assert_duty_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(duty_q));

  // R7: an accepted write while disabled lands in the duty register
  assert_duty_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !en_q) |=> (duty_q == $past(duty_i)));

endmodule

// File: rtl/throttle_slot_ctr.sv
module throttle_slot_ctr #(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              en_i,
  input  logic              tick_i,
  output logic [DUTY_W-1:0] slot_o
);

  localparam int                SLOTS     = 1 << DUTY_W;
  localparam logic [DUTY_W-1:0] LAST_SLOT = DUTY_W'(SLOTS - 1);

  logic [DUTY_W-1:0] slot_q;
  logic              adv;
  logic              wrap;

  assign adv  = en_i & tick_i;
  assign wrap = (slot_q == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (start_i) begin
      slot_q <= '0;               // a new session begins at slot 0
    end else if (adv) begin
      slot_q <= wrap ? '0 : slot_q + 1'b1;
    end
  end

  assign slot_o = slot_q;

  // R5: a session start leaves the counter at slot 0
  assert_start_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (slot_q == '0));

  // R3: without a tick the slot holds
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !start_i) |=> $stable(slot_q));

  // R3: the last slot wraps to zero on a tick
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !start_i && slot_q == LAST_SLOT) |=> (slot_q == '0));

endmodule

// File: rtl/throttle_pattern.sv
module throttle_pattern
  import throttle_pkg::*;
#(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DUTY_W-1:0] slot_i,
  output th_phase_e         phase_o
);

  always_comb begin
    if (!en_i)                phase_o = TH_IDLE;
    else if (duty_i == '0)    phase_o = TH_RESERVED;
    else if (slot_i < duty_i) phase_o = TH_RUN;
    else                      phase_o = TH_STOP;
  end

  // R4: a zero duty never produces a stop phase
  assert_zero_duty_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |-> !phase_stops(phase_o));

  // R3: slot 0 always runs under a nonzero duty
  assert_slot0_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && slot_i == '0) |-> !phase_stops(phase_o));

endmodule

// File: rtl/throttle_duty_gen.sv
module throttle_duty_gen
  import throttle_pkg::*;
#(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DUTY_W-1:0] wr_duty_i,
  input  logic              wr_enable_i,
  input  logic              tick_i,
  output logic              stop_clk_n_o
);

  logic              en;
  logic [DUTY_W-1:0] duty;
  logic              start;
  logic [DUTY_W-1:0] slot;
  th_phase_e         phase;

  throttle_ctrl_reg #(.DUTY_W(DUTY_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_i),
    .duty_i  (wr_duty_i),
    .en_i    (wr_enable_i),
    .en_o    (en),
    .duty_o  (duty),
    .start_o (start)
  );

  throttle_slot_ctr #(.DUTY_W(DUTY_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .en_i    (en),
    .tick_i  (tick_i),
    .slot_o  (slot)
  );

  throttle_pattern #(.DUTY_W(DUTY_W)) u_pat (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en),
    .duty_i  (duty),
    .slot_i  (slot),
    .phase_o (phase)
  );

  assign stop_clk_n_o = ~phase_stops(phase);

  // R2: disabled means the clock request stays released
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> stop_clk_n_o);

  // R3: a stop request always lies at or past the programmed duty slot
  assert_stop_past_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_clk_n_o |-> (en && duty != '0 && slot >= duty));

endmodule

// File: tb/throttle_duty_gen_bench.sv
`timescale 1ns/1ps
module throttle_duty_gen_bench;

  localparam int W     = 3;
  localparam int SLOTS = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [W-1:0] wd = '0;
  logic         we = 1'b0;
  logic         tk = 1'b0;
  logic         stop_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  bit         m_en   = 1'b0;
  bit [W-1:0] m_duty = '0;
  bit [W-1:0] m_slot = '0;

  always #2 clk = ~clk;

  throttle_duty_gen #(.DUTY_W(W)) u_throttle_duty_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (wr),
    .wr_duty_i    (wd),
    .wr_enable_i  (we),
    .tick_i       (tk),
    .stop_clk_n_o (stop_n)
  );

  function automatic bit exp_stop_n();
    return !(m_en && m_duty != 0 && m_slot >= m_duty);
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: stop_clk_n=%0b expected %0b (en=%0b duty=%0d slot=%0d)",
               tag, act, exp, m_en, m_duty, m_slot);
    end
  endtask

  // Called at a negedge: drive, advance model, wait one cycle, check.
  task automatic step(input bit w, input bit [W-1:0] d, input bit e,
                      input bit t, input string tag);
    bit rise;
    wr = w; wd = d; we = e; tk = t;
    rise = w && e && !m_en;
    if (rise) m_slot = '0;
    else if (m_en && t) m_slot = m_slot + 1'b1;
    if (w) begin
      if (!m_en) m_duty = d;
      m_en = e;
    end
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; tk = 1'b0;
    check(tag, stop_n, exp_stop_n());
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int runs;
    void'($urandom(32'h5eed_7a11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", stop_n, 1'b1);

    // R2: ticks with enable low
    for (int i = 0; i < 10; i++) step(0, '0, 0, 1, "R2 disabled");

    // R7: duty and enable in one write, then R3 pattern for two frames
    step(1, 3'd3, 1, 1, "R5 start ignores tick");
    for (int i = 0; i < 2 * SLOTS; i++) step(0, '0, 0, 1, "R3 pattern N=3");
    // R3: no tick, slot holds
    for (int i = 0; i < 5; i++) step(0, '0, 0, 0, "R3 hold");

    // R6: duty write while enabled ignored, pattern keeps N=3
    step(1, 3'd6, 1, 0, "R6 ignored write");
    for (int i = 0; i < SLOTS; i++) step(0, '0, 0, 1, "R6 pattern kept");

    // proper reprogram sequence
    step(1, 3'd6, 0, 1, "R6 clear enable");
    step(1, 3'd5, 0, 1, "R7 write while disabled");
    step(0, '0, 0, 1, "R2 disabled after write");
    step(1, 3'd0, 1, 0, "R7 enable");  // duty field written too, since disabled
    // that write carried zero: reserved
    for (int i = 0; i < 2 * SLOTS; i++) step(0, '0, 0, 1, "R4 zero duty");

    // R8: count run slots per frame for every nonzero duty
    for (int n = 1; n < SLOTS; n++) begin
      step(1, '0, 0, 0, "R2 clear");
      step(1, W'(n), 1, 1, "R5 restart");
      runs = (stop_n === 1'b1) ? 1 : 0;
      for (int s = 1; s < SLOTS; s++) begin
        step(0, '0, 0, 1, "R8 frame");
        if (stop_n === 1'b1) runs++;
      end
      checks++;
      if (runs != n) begin
        errors++;
        $display("FAIL R8: run slots=%0d expected %0d", runs, n);
      end
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit w;
      w = ($urandom_range(0, 9) == 0);
      step(w, W'($urandom), $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
           "R3 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule